// File: doc/BRIEF.md
# Serial Stuck-At Fault Simulation Engine

This block runs a complete single-stuck-at fault campaign in hardware on a small built-in combinational circuit under test. The circuit has three primary inputs and one output and is described as 25 numbered lines: the inputs, the fanout branches and every gate output each count as one line. Any single line can be forced to a constant, which models that line being stuck low or stuck high.

After a start request the engine first applies all eight input patterns to the fault-free circuit and stores the eight responses as a golden table. It then works through the fault list one fault at a time and replays the patterns, one per clock, against the same circuit with that fault forced. The first pattern whose output differs from the stored response marks the fault as detected and ends its replay at once. When every fault has been processed, the engine raises a one-cycle completion pulse. The number of detected faults, a per-fault detection vector and the coverage in whole percent then stay on the outputs until the next run starts.

Top module: `fsp_engine`

## Requirements
- R1: In reset, and on the cycle after it, busy and done are low and det_count, det_vec and coverage_pct are zero. total_faults always reads 50.
- R2: Faults are visited in order of line number 1 to 25, with stuck-at-0 before stuck-at-1 on each line. The fault with stuck value v on line n owns det_vec bit 2*(n-1)+v.
- R3: The circuit under test is defined as follows. Input a drives line 1, b drives line 2 and c drives line 3; a pattern value p has a = p[2], b = p[1], c = p[0]. Lines 4 and 5 are two fanout branches of line 2. Line 6 = OR(1,4), line 7 = NOT(6), line 8 = NOR(5,3), line 9 = NOT(8), line 10 = NOT(9), line 11 = NAND(7,10). Lines 12 to 25 each take the previous line as their input: the even lines 12 to 22 invert it and the other lines buffer it. Line 25 is the output. The fault-free output is 0 for pattern 000 and 1 for every other pattern.
- R4: start is accepted only when busy and done are both low. On the cycle after acceptance, busy is high and det_count and det_vec are zero.
- R5: A fault's det_vec bit is set when some pattern makes the faulted output differ from the fault-free output. For the circuit of R3, only the stuck-at-0 faults on lines 4 and 5 (bits 6 and 8) stay undetected, so det_count ends at 48.
- R6: Patterns are applied in ascending order 000 to 111, one per clock: first in a fault-free pass of 8 cycles, and then for each fault until its first detecting pattern or until the last pattern. done rises 8 + S clock edges after the edge that accepted start, where S is the sum over all faults of (index of the first detecting pattern + 1), with 8 counted for an undetected fault.
- R7: done is high for exactly one cycle. busy is never high together with done, and busy falls in the cycle in which done rises.
- R8: det_count always equals the number of set bits in det_vec and grows by at most one per cycle.
- R9: coverage_pct equals det_count * 100 / 50, that is, twice det_count.
- R10: A start pulse while busy is high, or in the done cycle, has no effect: the run length and the results are unchanged, and no new run begins.
- R11: While the engine is idle, det_vec and det_count hold their values until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a campaign |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | One-cycle completion pulse |
| det_count | output | 6 | Number of detected faults |
| total_faults | output | 6 | Size of the fault list (50) |
| coverage_pct | output | 7 | Fault coverage in whole percent |
| det_vec | output | 50 | Per-fault detected flags, indexed as in R2 |

## Verification
The cleared results and the raised busy are due one clock edge after the edge that accepts start. The completion pulse is due exactly 8 + S edges after that edge, with S computed in the bench from its own evaluation of the circuit under every fault. The bench counts rising edges from the accepting edge and samples two nanoseconds after each edge, so every comparison reads settled register outputs at the exact edge number the requirement predicts. The outputs are checked again one edge after the pulse and after a random idle gap, which checks the single-cycle pulse, the ignored start requests and the held results.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam int unsigned N_IN     = 3;
    localparam int unsigned N_LINES  = 25;
    localparam int unsigned N_PAT    = 1 << N_IN;
    localparam int unsigned N_FAULTS = 2 * N_LINES;
    localparam int unsigned OUT_LINE = N_LINES;
    localparam int unsigned LINE_W   = $clog2(N_LINES + 1);
    localparam int unsigned FID_W    = $clog2(N_FAULTS);
    localparam int unsigned CNT_W    = $clog2(N_FAULTS + 1);
    localparam int unsigned PCT_W    = 7;
    localparam int unsigned CHAIN_LO = 12;
    localparam int unsigned INV_HI   = 22;

    typedef enum logic [2:0] {
        G_PI,
        G_FAN,
        G_BUF,
        G_NOT,
        G_OR,
        G_NOR,
        G_AND,
        G_NAND
    } gate_kind_e;

    typedef struct packed {
        gate_kind_e          kind;
        logic [LINE_W-1:0]   src_a;
        logic [LINE_W-1:0]   src_b;
    } line_def_t;

    typedef struct packed {
        logic                active;
        logic [LINE_W-1:0]   line;
        logic                stuck_val;
    } fault_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GOLD,
        ST_SCAN,
        ST_DONE
    } eng_state_e;

    function automatic line_def_t mk(input gate_kind_e k, input int unsigned a,
                                     input int unsigned b);
        line_def_t d;
        d.kind  = k;
        d.src_a = LINE_W'(a);
        d.src_b = LINE_W'(b);
        return d;
    endfunction

    // Netlist of the circuit under test; sources always have lower numbers.
    function automatic line_def_t line_def(input int unsigned n);
        line_def_t d;
        case (n)
            1:       d = mk(G_PI,   2, 0);
            2:       d = mk(G_PI,   1, 0);
            3:       d = mk(G_PI,   0, 0);
            4:       d = mk(G_FAN,  2, 0);
            5:       d = mk(G_FAN,  2, 0);
            6:       d = mk(G_OR,   1, 4);
            7:       d = mk(G_NOT,  6, 0);
            8:       d = mk(G_NOR,  5, 3);
            9:       d = mk(G_NOT,  8, 0);
            10:      d = mk(G_NOT,  9, 0);
            11:      d = mk(G_NAND, 7, 10);
            default: begin
                if (n <= INV_HI && (n % 2) == 0)
                    d = mk(G_NOT, n - 1, 0);
                else
                    d = mk(G_BUF, n - 1, 0);
            end
        endcase
        return d;
    endfunction

    function automatic logic [FID_W-1:0] fault_id(input logic [LINE_W-1:0] line,
                                                  input logic stuck_val);
        return FID_W'((int'(line) - 1) * 2 + int'(stuck_val));
    endfunction

    function automatic logic [PCT_W-1:0] pct_of(input logic [CNT_W-1:0] cnt);
        return PCT_W'((int'(cnt) * 100) / int'(N_FAULTS));
    endfunction

endpackage

// File: rtl/fsp_netlist.sv
module fsp_netlist
    import fsp_pkg::*;
(
    input  logic [N_IN-1:0] pat_i,
    input  fault_t          fault_i,
    output logic            y_o
);

    logic lv [1:N_LINES];

    for (genvar ln = 1; ln <= N_LINES; ln++) begin : g_line
        localparam line_def_t D  = line_def(ln);
        localparam int        IA = int'(D.src_a);
        localparam int        IB = int'(D.src_b);

        logic raw;
        logic hit;

        if (D.kind == G_PI) begin : g_pi
            assign raw = pat_i[IA];
        end else if (D.kind == G_FAN || D.kind == G_BUF) begin : g_buf
            assign raw = lv[IA];
        end else if (D.kind == G_NOT) begin : g_not
            assign raw = ~lv[IA];
        end else if (D.kind == G_OR) begin : g_or
            assign raw = lv[IA] | lv[IB];
        end else if (D.kind == G_NOR) begin : g_nor
            assign raw = ~(lv[IA] | lv[IB]);
        end else if (D.kind == G_AND) begin : g_and
            assign raw = lv[IA] & lv[IB];
        end else begin : g_nand
            assign raw = ~(lv[IA] & lv[IB]);
        end

        assign hit    = fault_i.active && (fault_i.line == LINE_W'(ln));
        assign lv[ln] = hit ? fault_i.stuck_val : raw;
    end

    assign y_o = lv[OUT_LINE];

endmodule

// File: rtl/fsp_golden.sv
module fsp_golden
    import fsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we_i,
    input  logic [N_IN-1:0] pat_i,
    input  logic            y_i,
    output logic            gold_o
);

    logic [N_PAT-1:0] tbl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
        end else if (we_i) begin
            tbl_q[pat_i] <= y_i;
        end
    end

    assign gold_o = tbl_q[pat_i];

endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
    import fsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             mismatch_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [N_IN-1:0]  pat_o,
    output fault_t           fault_o,
    output logic             gold_we_o,
    output logic             clear_o,
    output logic             rec_valid_o,
    output logic             rec_hit_o,
    output logic [FID_W-1:0] rec_id_o
);

    eng_state_e        st_q;
    logic [N_IN-1:0]   pat_q;
    logic [LINE_W-1:0] line_q;
    logic              val_q;

    logic last_pat;
    logic last_fault;
    logic retire;

    assign last_pat   = (pat_q == N_IN'(N_PAT - 1));
    assign last_fault = (line_q == LINE_W'(N_LINES)) && val_q;
    assign retire     = (st_q == ST_SCAN) && (mismatch_i || last_pat);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pat_q  <= '0;
            line_q <= LINE_W'(1);
            val_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q   <= ST_GOLD;
                        pat_q  <= '0;
                        line_q <= LINE_W'(1);
                        val_q  <= 1'b0;
                    end
                end
                ST_GOLD: begin
                    pat_q <= pat_q + 1'b1;
                    if (last_pat) begin
                        st_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (retire) begin
                        pat_q <= '0;
                        if (last_fault) begin
                            st_q <= ST_DONE;
                        end else if (val_q) begin
                            line_q <= line_q + 1'b1;
                            val_q  <= 1'b0;
                        end else begin
                            val_q <= 1'b1;
                        end
                    end else begin
                        pat_q <= pat_q + 1'b1;
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        busy_o            = (st_q == ST_GOLD) || (st_q == ST_SCAN);
        done_o            = (st_q == ST_DONE);
        pat_o             = pat_q;
        fault_o.active    = (st_q == ST_SCAN);
        fault_o.line      = line_q;
        fault_o.stuck_val = val_q;
        gold_we_o         = (st_q == ST_GOLD);
        clear_o           = (st_q == ST_IDLE) && start_i;
        rec_valid_o       = retire;
        rec_hit_o         = mismatch_i;
        rec_id_o          = fault_id(line_q, val_q);
    end

endmodule

// File: rtl/fsp_tally.sv
module fsp_tally
    import fsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_i,
    input  logic                rec_valid_i,
    input  logic                rec_hit_i,
    input  logic [FID_W-1:0]    rec_id_i,
    output logic [N_FAULTS-1:0] vec_o,
    output logic [CNT_W-1:0]    count_o
);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            vec_o   <= '0;
            count_o <= '0;
        end else if (rec_valid_i && rec_hit_i) begin
            vec_o[rec_id_i] <= 1'b1;
            count_o         <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/fsp_engine.sv
module fsp_engine
    import fsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic [CNT_W-1:0]    det_count,
    output logic [CNT_W-1:0]    total_faults,
    output logic [PCT_W-1:0]    coverage_pct,
    output logic [N_FAULTS-1:0] det_vec
);

    logic [N_IN-1:0]  pat;
    fault_t           fault;
    logic             y;
    logic             gold;
    logic             gold_we;
    logic             clear;
    logic             rec_valid;
    logic             rec_hit;
    logic [FID_W-1:0] rec_id;

    fsp_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .mismatch_i  (y != gold),
        .busy_o      (busy),
        .done_o      (done),
        .pat_o       (pat),
        .fault_o     (fault),
        .gold_we_o   (gold_we),
        .clear_o     (clear),
        .rec_valid_o (rec_valid),
        .rec_hit_o   (rec_hit),
        .rec_id_o    (rec_id)
    );

    fsp_netlist cut_i (
        .pat_i   (pat),
        .fault_i (fault),
        .y_o     (y)
    );

    fsp_golden gold_i (
        .clk    (clk),
        .rst    (rst),
        .we_i   (gold_we),
        .pat_i  (pat),
        .y_i    (y),
        .gold_o (gold)
    );

    fsp_tally tally_i (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear),
        .rec_valid_i (rec_valid),
        .rec_hit_i   (rec_hit),
        .rec_id_i    (rec_id),
        .vec_o       (det_vec),
        .count_o     (det_count)
    );

    assign total_faults = CNT_W'(N_FAULTS);
    assign coverage_pct = pct_of(det_count);

endmodule

// File: rtl/fsp_engine_chk.sv
module fsp_engine_chk
    import fsp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [CNT_W-1:0]    det_count,
    input logic [PCT_W-1:0]    coverage_pct,
    input logic [N_FAULTS-1:0] det_vec
);

    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r4_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> (busy && det_count == '0 && det_vec == '0));

    a_r8_popcount: assert property (@(posedge clk) disable iff (rst)
        int'(det_count) == $countones(det_vec));

    a_r8_step: assert property (@(posedge clk) disable iff (rst)
        busy |=> (det_count == $past(det_count)) || (det_count == $past(det_count) + 1'b1));

    a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && (done || !start)) |=> ($stable(det_vec) && $stable(det_count)));

    a_r9_pct_twice: assert property (@(posedge clk) disable iff (rst)
        coverage_pct == PCT_W'(det_count) * PCT_W'(2));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(det_count) <= int'(N_FAULTS));

endmodule

bind fsp_engine fsp_engine_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .det_count    (det_count),
    .coverage_pct (coverage_pct),
    .det_vec      (det_vec)
);

// File: tb/fsp_engine_tb.sv
module fsp_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic [5:0]  det_count;
    logic [5:0]  total_faults;
    logic [6:0]  coverage_pct;
    logic [49:0] det_vec;

    int n_chk = 0;
    int n_bad = 0;

    logic [49:0] exp_vec;
    int          exp_cnt;
    int          exp_run;

    always #4 clk = ~clk;

    fsp_engine dut_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .busy         (busy),
        .done         (done),
        .det_count    (det_count),
        .total_faults (total_faults),
        .coverage_pct (coverage_pct),
        .det_vec      (det_vec)
    );

    // Reference model of the circuit of R3, with an optional stuck line.
    function automatic bit model_out(bit [2:0] p, bit act, int fl, bit fv);
        bit v [1:25];
        for (int n = 1; n <= 25; n++) begin
            bit r;
            case (n)
                1:  r = p[2];
                2:  r = p[1];
                3:  r = p[0];
                4:  r = v[2];
                5:  r = v[2];
                6:  r = v[1] | v[4];
                7:  r = !v[6];
                8:  r = !(v[5] | v[3]);
                9:  r = !v[8];
                10: r = !v[9];
                11: r = !(v[7] & v[10]);
                default: r = (n <= 22 && (n % 2) == 0) ? !v[n-1] : v[n-1];
            endcase
            if (act && n == fl) r = fv;
            v[n] = r;
        end
        return v[25];
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic build_expect();
        exp_vec = '0;
        exp_cnt = 0;
        exp_run = 8;
        for (int ln = 1; ln <= 25; ln++) begin
            for (int sv = 0; sv < 2; sv++) begin
                int first;
                first = -1;
                for (int p = 0; p < 8; p++) begin
                    if (first < 0 &&
                        model_out(3'(p), 1'b1, ln, sv[0]) != model_out(3'(p), 1'b0, 0, 1'b0))
                        first = p;
                end
                if (first >= 0) begin
                    exp_vec[(ln - 1) * 2 + sv] = 1'b1;
                    exp_cnt++;
                    exp_run += first + 1;
                end else begin
                    exp_run += 8;
                end
            end
        end
    endtask

    task automatic check_reset_state(string tag);
        check(busy == 1'b0, "R1", {tag, " busy"}, 64'(busy), 0);
        check(done == 1'b0, "R1", {tag, " done"}, 64'(done), 0);
        check(det_count == 0, "R1", {tag, " det_count"}, 64'(det_count), 0);
        check(det_vec == '0, "R1", {tag, " det_vec"}, 64'(det_vec), 0);
        check(coverage_pct == 0, "R1", {tag, " coverage"}, 64'(coverage_pct), 0);
        check(total_faults == 6'd50, "R1", {tag, " total_faults"}, 64'(total_faults), 50);
    endtask

    task automatic do_reset(int cycles);
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        repeat (cycles) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
    endtask

    // One campaign; spur >= 1 pulses start at that busy cycle index,
    // at_done pulses start in the done cycle.
    task automatic run_campaign(int gap, int spur, bit at_done);
        int j;
        logic [49:0] held;
        repeat (gap) @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        j = 0;
        while (j < 3000) begin
            @(negedge clk);
            start = (j == spur);
            @(posedge clk);
            #2;
            j++;
            if (j == 1) begin
                check(busy == 1'b1, "R4", "busy after start", 64'(busy), 1);
                check(det_count == 0 && det_vec == '0, "R4", "cleared after start",
                      64'(det_vec), 0);
            end
            if (done) break;
        end
        check(j == exp_run, "R6", "cycles to done", 64'(j), 64'(exp_run));
        check(busy == 1'b0, "R7", "busy low with done", 64'(busy), 0);
        check(det_vec == exp_vec, "R5", "detected vector (R2 order, R3 netlist)",
              64'(det_vec), 64'(exp_vec));
        check(det_vec[6] == 1'b0 && det_vec[8] == 1'b0, "R5", "bits 6 and 8 undetected",
              64'({det_vec[8], det_vec[6]}), 0);
        check(int'(det_count) == exp_cnt && exp_cnt == 48, "R8", "det_count",
              64'(det_count), 48);
        check(coverage_pct == 7'd96, "R9", "coverage", 64'(coverage_pct), 96);
        @(negedge clk);
        start = at_done;
        @(posedge clk);
        #2;
        check(done == 1'b0, "R7", "done single cycle", 64'(done), 0);
        check(busy == 1'b0, "R10", "no restart after done-cycle start", 64'(busy), 0);
        @(negedge clk);
        start = 1'b0;
        held = det_vec;
        repeat ($urandom_range(5, 40)) @(negedge clk);
        @(posedge clk);
        #2;
        check(busy == 1'b0, "R10", "still idle", 64'(busy), 0);
        check(det_vec == held && det_count == 6'd48, "R11", "results held while idle",
              64'(det_vec), 64'(held));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f3c_2a57));
        build_expect();
        // Golden per R3: output 0 only for pattern 000.
        for (int p = 0; p < 8; p++) begin
            if (model_out(3'(p), 1'b0, 0, 1'b0) != (p != 0))
                $display("FAIL R3 model golden: actual=%0d expected=%0d",
                         model_out(3'(p), 1'b0, 0, 1'b0), (p != 0));
        end

        do_reset(3);
        check_reset_state("after reset");

        // Directed: plain run, then start in the done cycle.
        run_campaign(0, -1, 1'b0);
        run_campaign(2, -1, 1'b1);
        // Directed: start pulses at the first and last busy cycles.
        run_campaign(1, 1, 1'b0);
        run_campaign(3, exp_run - 1, 1'b0);

        // Random gaps and random spurious start positions.
        for (int k = 0; k < 4; k++) begin
            run_campaign($urandom_range(0, 20), $urandom_range(1, exp_run - 1),
                         1'($urandom_range(0, 1)));
        end

        // Reset in the middle of a campaign.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat ($urandom_range(5, 150)) @(negedge clk);
        do_reset(3);
        check_reset_state("mid-run reset");

        run_campaign(0, -1, 1'b0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule